// File: doc/BRIEF.md
# Asynchronous Serial Receive Engine

This block receives asynchronous serial frames on one of two input lines. An external divider supplies a one-cycle enable tick at sixteen times the bit rate. When the line reaches its start level the engine waits half a bit and samples the line again to confirm the start bit. It then samples eight data bits, least significant first, one parity bit and one stop bit at the centre of each bit. Each finished frame goes into a receive buffer. The same clock edge updates the parity, framing and overrun flags and raises a one-cycle completion interrupt.

A frame with an error is still written to the buffer. An error-interrupt mask decides whether such a frame raises the interrupt. Clearing the receive enable drops any frame in progress and leaves the buffer, the flags and the interrupt untouched. A polarity input swaps the meaning of high and low on the line, and a pair select picks which of the two input lines is used. A one-cycle read strobe tells the engine that the buffer has been consumed.

Top module: `serial_rx_engine`

## Requirements
- R1: While rxEnable is 0 the line is not sampled: a complete frame driven on the line leaves rxData, the flags and rxIrq unchanged.
- R2: A start condition is taken only when the line is at the start level on a tick and is still at the start level 8 ticks later. A shorter low pulse returns the engine to idle without producing a frame.
- R3: After the start bit the engine samples every 16 ticks: 8 data bits, least significant bit first (the first data bit lands in rxData[0]), then a parity bit, then a stop bit.
- R4: On the clock edge that samples the stop bit, rxData takes the received byte, and rxIrq is 1 for exactly that one cycle when the frame raises an interrupt.
- R5: parityErr is set when the received parity bit differs from the XOR of the 8 data bits (even parity). framingErr is set when the stop bit is not at the idle level. Both flags are rewritten on every completed frame.
- R6: A frame with a parity, framing or overrun error is still written to rxData. With errIrqMask=0 it raises rxIrq. With errIrqMask=1 it raises no rxIrq. Error-free frames always raise rxIrq.
- R7: overrunErr is set when a frame completes while the previous buffer contents have not been read. It stays set until a one-cycle bufRead strobe, which clears it.
- R8: Clearing rxEnable in the middle of a frame stops reception at once. rxData and the flags keep their values and no rxIrq is raised.
- R9: With polarityNeg=0 the start level is low and the idle level is high. With polarityNeg=1 both levels are inverted, and the data bits are inverted back, so a frame sent in either logic yields the same byte.
- R10: pinSel=0 selects rxLine0 and pinSel=1 selects rxLine1. The line that is not selected has no effect.
- R11: After reset rxData is 0x00, all three flags are 0 and rxIrq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle enable at 16 times the bit rate |
| rxEnable | input | 1 | Receive enable; 0 aborts and idles |
| errIrqMask | input | 1 | 1 suppresses rxIrq for errored frames |
| polarityNeg | input | 1 | 0 selects positive logic, 1 selects negative logic |
| pinSel | input | 1 | Input line pair select |
| rxLine0 | input | 1 | Serial input, pair 0 |
| rxLine1 | input | 1 | Serial input, pair 1 |
| bufRead | input | 1 | One-cycle strobe: buffer consumed |
| rxData | output | 8 | Receive buffer |
| parityErr | output | 1 | Parity error of the last frame |
| framingErr | output | 1 | Framing error of the last frame |
| overrunErr | output | 1 | Frame completed over unread data |
| rxIrq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest state to reach is a masked overrun. It needs two frames to complete with no bufRead between them while errIrqMask is 1, so the second frame must be stored with no interrupt. The stimulus gets there by sending two clean frames back to back without a read, then clearing the flag with one read strobe.

The abort case needs rxEnable to fall partway through a frame while the line keeps toggling. The bench drops the enable after four data bits and raises it again only once the line has returned to idle.

A behavioural model in the bench counts ticks from the start edge and is compared with the outputs on every clock.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic parityEn;
    logic frameDone;
  } rxStrobe_t;

endpackage

// File: rtl/rx_line_select.sv
module rx_line_select (
  input  logic rxLine0,
  input  logic rxLine1,
  input  logic pinSel,
  input  logic polarityNeg,
  output logic lineBit
);
  logic rawBit;

  // Normalised: start level is 0, idle level is 1
  always_comb begin
    rawBit  = pinSel ? rxLine1 : rxLine0;
    lineBit = polarityNeg ? ~rawBit : rawBit;
  end
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rxu_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      rxEnable,
  input  logic      lineBit,
  output rxStrobe_t strobe
);
  localparam int CW   = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int HALF = OVERSAMPLE / 2;
  localparam int BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  rxState_e      state;
  logic [CW-1:0] tickCnt;
  logic [BW-1:0] bitIdx;
  logic          atCentre;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (!rxEnable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (baudTick) begin
      unique case (state)
        ST_IDLE: begin
          if (!lineBit) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tickCnt == CW'(HALF - 1)) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= lineBit ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        ST_DATA: begin
          if (atCentre) begin
            tickCnt <= '0;
            bitIdx  <= bitIdx + BW'(1);
            if (bitIdx == BW'(DATA_BITS - 1)) state <= ST_PARITY;
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        ST_PARITY: begin
          if (atCentre) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        ST_STOP: begin
          if (atCentre) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    atCentre         = (tickCnt == CW'(OVERSAMPLE - 1));
    strobe.shiftEn   = rxEnable && baudTick && atCentre && (state == ST_DATA);
    strobe.parityEn  = rxEnable && baudTick && atCentre && (state == ST_PARITY);
    strobe.frameDone = rxEnable && baudTick && atCentre && (state == ST_STOP);
  end

  // R8: a cleared enable leaves the engine idle on the next cycle
  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> state == ST_IDLE);

  // R3: at most one sampling strobe per cycle
  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shiftEn, strobe.parityEn, strobe.frameDone}));

  // R3: the parity sample directly follows the last data bit
  assert_parity_after_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.parityEn |-> bitIdx == '0);
endmodule

// File: rtl/rx_dpath.sv
module rx_dpath
  import rxu_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rxStrobe_t            strobe,
  input  logic                 lineBit,
  input  logic                 errIrqMask,
  input  logic                 bufRead,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 parityErr,
  output logic                 framingErr,
  output logic                 overrunErr,
  output logic                 rxIrq
);
  logic [DATA_BITS-1:0] shiftReg;
  logic                 parityBit;
  logic                 unread;
  logic                 newParErr;
  logic                 newFrmErr;
  logic                 ovrHit;

  always_comb begin
    newParErr = (^shiftReg) ^ parityBit;
    newFrmErr = ~lineBit;
    ovrHit    = strobe.frameDone && unread && !bufRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else begin
      if (strobe.shiftEn)  shiftReg  <= {lineBit, shiftReg[DATA_BITS-1:1]};
      if (strobe.parityEn) parityBit <= lineBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      overrunErr <= 1'b0;
      unread     <= 1'b0;
      rxIrq      <= 1'b0;
    end else begin
      rxIrq <= strobe.frameDone &&
               !(errIrqMask && (newParErr || newFrmErr || ovrHit));
      if (strobe.frameDone) begin
        rxData     <= shiftReg;
        parityErr  <= newParErr;
        framingErr <= newFrmErr;
        unread     <= 1'b1;
      end else if (bufRead) begin
        unread     <= 1'b0;
      end
      if (ovrHit)       overrunErr <= 1'b1;
      else if (bufRead) overrunErr <= 1'b0;
    end
  end

  // R4: completion interrupt is a single-cycle pulse
  assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

  // R8: buffer and frame flags move only at frame end
  assert_buffer_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.frameDone |=> $stable(rxData) && $stable(parityErr) && $stable(framingErr));

  // R7: a read with no frame ending clears the overrun flag
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    bufRead && !strobe.frameDone |=> !overrunErr);

  // R6: with the mask set, an interrupt only accompanies a clean frame
  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq && $past(errIrqMask) |-> !(parityErr || framingErr || overrunErr));
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import rxu_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 baudTick,
  input  logic                 rxEnable,
  input  logic                 errIrqMask,
  input  logic                 polarityNeg,
  input  logic                 pinSel,
  input  logic                 rxLine0,
  input  logic                 rxLine1,
  input  logic                 bufRead,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 parityErr,
  output logic                 framingErr,
  output logic                 overrunErr,
  output logic                 rxIrq
);
  logic      lineBit;
  rxStrobe_t strobe;

  rx_line_select u_sel (
    .rxLine0     (rxLine0),
    .rxLine1     (rxLine1),
    .pinSel      (pinSel),
    .polarityNeg (polarityNeg),
    .lineBit     (lineBit)
  );

  rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .rxEnable (rxEnable),
    .lineBit  (lineBit),
    .strobe   (strobe)
  );

  rx_dpath #(.DATA_BITS(DATA_BITS)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .lineBit    (lineBit),
    .errIrqMask (errIrqMask),
    .bufRead    (bufRead),
    .rxData     (rxData),
    .parityErr  (parityErr),
    .framingErr (framingErr),
    .overrunErr (overrunErr),
    .rxIrq      (rxIrq)
  );
endmodule

// File: tb/serial_rx_engine_bench.sv
`timescale 1ns/1ps
module serial_rx_engine_bench;
  localparam int BITCLK = 64; // 16 ticks x 4 clocks

  logic clk = 0, rstN = 0, baudTick = 0, rxEnable = 0, errIrqMask = 0;
  logic polarityNeg = 0, pinSel = 0, rxLine0 = 1, rxLine1 = 1, bufRead = 0;
  logic [7:0] rxData;
  logic parityErr, framingErr, overrunErr, rxIrq;

  int compared = 0, mismatched = 0, cycles = 0, irqSeen = 0, tickDiv = 0;

  // reference model state
  logic [7:0] mData = 0, mAcc = 0;
  logic mPe = 0, mFe = 0, mOv = 0, mIrq = 0, mUnread = 0, mBusy = 0, mPar = 0;
  int mTicks = 0;

  serial_rx_engine u_serial_rx_engine (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxEnable(rxEnable),
    .errIrqMask(errIrqMask), .polarityNeg(polarityNeg), .pinSel(pinSel),
    .rxLine0(rxLine0), .rxLine1(rxLine1), .bufRead(bufRead),
    .rxData(rxData), .parityErr(parityErr), .framingErr(framingErr),
    .overrunErr(overrunErr), .rxIrq(rxIrq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tickDiv  = (tickDiv + 1) % 4;
    baudTick = (tickDiv == 3);
  end

  // behavioural reference: counts ticks since the start edge
  always @(posedge clk) begin
    logic ln, done, ovNow, pe, fe;
    int k;
    ln = (pinSel ? rxLine1 : rxLine0) ^ polarityNeg;
    done = 0; ovNow = 0; pe = 0; fe = 0;
    if (!rstN) begin
      mData = 0; mPe = 0; mFe = 0; mOv = 0; mIrq = 0; mUnread = 0; mBusy = 0;
    end else begin
      if (!rxEnable) mBusy = 0;
      else if (baudTick) begin
        if (!mBusy) begin
          if (!ln) begin mBusy = 1; mTicks = 0; end
        end else begin
          mTicks++;
          if (mTicks >= 8 && (mTicks - 8) % 16 == 0) begin
            k = (mTicks - 8) / 16;
            if (k == 0) begin if (ln) mBusy = 0; end
            else if (k <= 8) mAcc[k-1] = ln;
            else if (k == 9) mPar = ln;
            else begin
              done = 1; mBusy = 0;
              pe = (^mAcc) != mPar; fe = !ln;
            end
          end
        end
      end
      mIrq = 0;
      if (done) begin
        ovNow = mUnread && !bufRead;
        mData = mAcc; mPe = pe; mFe = fe; mUnread = 1;
        if (ovNow) mOv = 1; else if (bufRead) mOv = 0;
        mIrq = !(errIrqMask && (pe || fe || ovNow));
      end else if (bufRead) begin
        mUnread = 0; mOv = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #2;
    cycles++;
    if (rstN) begin
      if (rxIrq) irqSeen++;
      chk("R3 model rxData", rxData, mData);
      chk("R5 model parityErr", parityErr, mPe);
      chk("R5 model framingErr", framingErr, mFe);
      chk("R7 model overrunErr", overrunErr, mOv);
      chk("R6 model rxIrq", rxIrq, mIrq);
    end
    if (cycles > 150000) begin
      chk("watchdog", 1, 0);
      finishRun();
    end
  end

  task automatic setLevel(input logic lvl);
    logic phys, noise;
    phys  = lvl ^ polarityNeg;
    noise = polarityNeg;     // start level on the unused line
    if (pinSel) begin rxLine1 = phys; rxLine0 = noise; end
    else        begin rxLine0 = phys; rxLine1 = noise; end
  endtask

  task automatic holdBit(input logic lvl);
    setLevel(lvl);
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic p, input logic s);
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(d[i]);
    holdBit(p);
    holdBit(s);
    holdBit(1'b1);
    holdBit(1'b1);
  endtask

  task automatic readBuf();
    bufRead = 1; @(negedge clk); bufRead = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int irqBefore;
    rxLine0 = 1; rxLine1 = 1;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R11 reset rxData", rxData, 0);
    chk("R11 reset flags", {parityErr, framingErr, overrunErr, rxIrq}, 0);
    rxEnable = 1;
    repeat (20) @(negedge clk);

    sendFrame(8'hB4, 1'b0, 1'b1);
    chk("R3 lsb-first data", rxData, 8'hB4);
    chk("R4 irq count", irqSeen, 1);
    chk("R5 clean flags", {parityErr, framingErr}, 0);
    readBuf();

    sendFrame(8'h3C, 1'b1, 1'b1);
    chk("R5 parity error", parityErr, 1);
    chk("R6 errored stored", rxData, 8'h3C);
    chk("R6 mask0 irq", irqSeen, 2);
    readBuf();

    errIrqMask = 1;
    sendFrame(8'h0F, 1'b0, 1'b0);
    chk("R5 framing error", {framingErr, parityErr}, 2'b10);
    chk("R6 errored stored masked", rxData, 8'h0F);
    chk("R6 mask1 no irq", irqSeen, 2);
    readBuf();

    sendFrame(8'h81, 1'b0, 1'b1);
    chk("R6 clean frame irq under mask", irqSeen, 3);
    errIrqMask = 0;
    sendFrame(8'h7E, 1'b0, 1'b1);
    chk("R7 overrun set", overrunErr, 1);
    chk("R7 overrun data", rxData, 8'h7E);
    sendFrame(8'h01, 1'b1, 1'b1);
    chk("R7 overrun persists", overrunErr, 1);
    chk("R6 overrun irq mask0", irqSeen, 5);
    readBuf();
    chk("R7 read clears overrun", overrunErr, 0);

    sendFrame(8'h55, 1'b0, 1'b1);
    errIrqMask = 1;
    sendFrame(8'h66, 1'b0, 1'b1);
    chk("R7 masked overrun flag", overrunErr, 1);
    chk("R6 masked overrun no irq", irqSeen, 6);
    readBuf();
    errIrqMask = 0;

    irqBefore = irqSeen;
    setLevel(1'b0); repeat (8) @(negedge clk);
    setLevel(1'b1); repeat (300) @(negedge clk);
    chk("R2 short pulse ignored", irqSeen, irqBefore);
    chk("R2 buffer kept", rxData, 8'h66);

    rxEnable = 0;
    sendFrame(8'hE7, 1'b0, 1'b1);
    chk("R1 disabled no irq", irqSeen, irqBefore);
    chk("R1 disabled buffer kept", rxData, 8'h66);
    rxEnable = 1;
    repeat (20) @(negedge clk);

    holdBit(1'b0);
    for (int i = 0; i < 4; i++) holdBit(i[0]);
    rxEnable = 0;
    for (int i = 0; i < 6; i++) holdBit(i[0]);
    holdBit(1'b1);
    rxEnable = 1;
    repeat (20) @(negedge clk);
    chk("R8 abort buffer kept", rxData, 8'h66);
    chk("R8 abort no irq", irqSeen, irqBefore);
    chk("R8 abort flags kept", {parityErr, framingErr, overrunErr}, 0);

    polarityNeg = 1; setLevel(1'b1);
    repeat (BITCLK) @(negedge clk);
    sendFrame(8'hC3, 1'b0, 1'b1);
    chk("R9 negative logic data", rxData, 8'hC3);
    chk("R9 negative logic irq", irqSeen, irqBefore + 1);
    readBuf();

    polarityNeg = 0; pinSel = 1; setLevel(1'b1);
    repeat (BITCLK) @(negedge clk);
    sendFrame(8'h5A, 1'b0, 1'b1);
    chk("R10 pair1 data", rxData, 8'h5A);
    chk("R10 pair1 flags", {parityErr, framingErr}, 0);
    chk("R10 irq count", irqSeen, irqBefore + 2);
    readBuf();

    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule